// File: doc/BRIEF.md
# Bus-Mastering Thermal Sensor Sequencer

This block samples up to four remote temperature sensing points through an ADC that lives elsewhere on the chip. It has no converter of its own. It acts as a master on a simple memory-mapped bus. Each step of a conversion is a bus write or read to an address that software has placed in the block's configuration registers.

A pacer starts a sampling round on a fixed period. In each round the sequencer visits every enabled sensor in ascending index order. For each one it can write that sensor's mux value to the analog-mux address and write a channel word to the ADC mux address; each of these two writes has its own enable. It always writes the enable word to the ADC enable address. It then polls a status word until a programmable bit reaches a programmable level, with a programmable gap between polls. When the bit matches, it takes the voltage from that same word or from a second read, applies a right shift, and stores the low 12 bits in the sensor's measurement register. That register has a sticky updated flag, and a read of the register clears the flag.

Polling is bounded by a programmable limit. When the limit is reached, the sequencer pulses an error output and moves on to the next sensor. An all-ones limit means polling never gives up.

Top module: `tsq_top`

## Requirements
- R1: After reset, all measurement registers read 0 with the updated flag (bit 31) clear, and no bus request is raised.
- R2: Rounds start once every unit×256×interval clocks. The unit is a 10-bit field at address 0x01 and the interval is bits [9:0] at address 0x02. If either field is 0, no round starts.
- R3: Within a round, enabled sensors are visited in ascending index. For each one, the sequence is a write of the sensor's mux value (address 0x10+i) to the analog-mux address, sent only if write-control (0x05) bit 0 is set. Next comes a write of the channel word to the ADC mux address, sent only if bit 1 is set. Last comes a write of the enable word to the enable address.
- R4: A poll result is valid when status bit [4:0] of the valid-config register (0x06) equals bit 5 of that register (1 = active high).
- R5: With read-control (0x07) at 0, the voltage is taken from the polled status word. With it at 1, one extra read of the voltage address supplies the voltage.
- R6: The stored value is the voltage word shifted right by the shift register (0x08, 5 bits), keeping the low 12 bits in bits [11:0] of the measurement register at 0x18+i.
- R7: Storing a result sets bit 31 of that measurement register. Reading the register clears the flag.
- R8: A sensor whose bit in the enable mask (0x00, bits [3:0]) is clear gets no bus traffic, and its measurement register keeps its value and flag.
- R9: If polling lasts at least the timeout (0x04) clocks and the status is still not valid, the error output pulses, no result is stored, and the next sensor is processed. A timeout of 0xFFFFFFFF never expires.
- R10: Register 0x02 holds a 10-bit filter interval in bits [25:16] beside the sensor interval, and both fields read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe (clears the updated flag when a measurement register is read) |
| cfg_addr | input | 5 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational from cfg_addr) |
| m_req | output | 1 | Master request, held until acknowledged |
| m_we | output | 1 | Master write (1) or read (0) |
| m_addr | output | 32 | Master address |
| m_wdata | output | 32 | Master write data |
| m_rdata | input | 32 | Master read data, valid with m_ack |
| m_ack | input | 1 | Master acknowledge |
| tmo_err | output | 1 | One-cycle pulse when polling for a sensor times out |

## Verification
The bench compares every master write against a queue of expected writes built from the enable mask and the write-control bits. A sequencer that visits sensors out of order, skips a mux write, or touches a disabled sensor shows up as a mismatched or leftover entry. The behavioural ADC first returns several not-ready polls, and it also runs with an inverted valid level and a nonzero shift. This exposes a sequencer that tests the wrong bit or polarity, or that takes the voltage from the status word when a separate read was configured: the stored value would be the junk field. A stuck conversion checks that a finite timeout skips only that sensor and that the all-ones limit keeps polling. The start delay after the interval is programmed is measured to confirm the unit-times-256 prescale.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  localparam int TSQ_NS  = 4;
  localparam int TSQ_SIW = $clog2(TSQ_NS);
  localparam int TSQ_AW  = 5;

  localparam logic [TSQ_AW-1:0] RA_MASK  = 5'h00;
  localparam logic [TSQ_AW-1:0] RA_UNIT  = 5'h01;
  localparam logic [TSQ_AW-1:0] RA_IVL   = 5'h02;
  localparam logic [TSQ_AW-1:0] RA_GAP   = 5'h03;
  localparam logic [TSQ_AW-1:0] RA_TMO   = 5'h04;
  localparam logic [TSQ_AW-1:0] RA_WRC   = 5'h05;
  localparam logic [TSQ_AW-1:0] RA_VCFG  = 5'h06;
  localparam logic [TSQ_AW-1:0] RA_RDC   = 5'h07;
  localparam logic [TSQ_AW-1:0] RA_SHIFT = 5'h08;
  localparam logic [TSQ_AW-1:0] RA_APNP  = 5'h09;
  localparam logic [TSQ_AW-1:0] RA_AMUX  = 5'h0A;
  localparam logic [TSQ_AW-1:0] RA_AEN   = 5'h0B;
  localparam logic [TSQ_AW-1:0] RA_AVLD  = 5'h0C;
  localparam logic [TSQ_AW-1:0] RA_AVOLT = 5'h0D;
  localparam logic [TSQ_AW-1:0] RA_DMUX  = 5'h0E;
  localparam logic [TSQ_AW-1:0] RA_DEN   = 5'h0F;
  localparam logic [TSQ_AW-1:0] RA_SMUX0 = 5'h10;
  localparam logic [TSQ_AW-1:0] RA_MEAS0 = 5'h18;

  typedef enum logic [2:0] {
    S_IDLE, S_WR_PNP, S_WR_MUX, S_WR_EN, S_RD_VLD, S_GAP, S_RD_VOLT
  } eng_state_t;

  // lowest enabled index at or above 'from'; MSB is the found flag
  function automatic logic [TSQ_SIW:0] pick_next(input logic [TSQ_NS-1:0] mask, input int from);
    logic [TSQ_SIW:0] r;
    r = '0;
    for (int i = TSQ_NS - 1; i >= 0; i--)
      if (i >= from && mask[i]) r = {1'b1, TSQ_SIW'(i)};
    return r;
  endfunction

  function automatic logic valid_seen(input logic [31:0] w, input logic [5:0] vcfg);
    return w[vcfg[4:0]] == vcfg[5];
  endfunction

  function automatic logic [11:0] scale_sample(input logic [31:0] w, input logic [4:0] sh);
    logic [31:0] t;
    t = w >> sh;
    return t[11:0];
  endfunction

  function automatic eng_state_t entry_state(input logic [1:0] wc);
    if (wc[0]) return S_WR_PNP;
    if (wc[1]) return S_WR_MUX;
    return S_WR_EN;
  endfunction
endpackage

// File: rtl/tsq_pacer.sv
module tsq_pacer #(
  parameter int UNIT_SHIFT = 8,
  parameter int FW         = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] unit_cnt,
  input  logic [FW-1:0] ivl_cnt,
  output logic          round_start
);
  localparam int PW = FW + UNIT_SHIFT;

  logic [PW-1:0] pre;
  logic [FW-1:0] ticks;
  logic          run;
  logic          unit_tick;
  logic [PW-1:0] pre_lim;

  assign run       = (unit_cnt != '0) && (ivl_cnt != '0);
  assign pre_lim   = {unit_cnt, {UNIT_SHIFT{1'b0}}} - PW'(1);
  assign unit_tick = run && (pre == pre_lim);
  assign round_start = unit_tick && (ticks == ivl_cnt - FW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      pre   <= '0;
      ticks <= '0;
    end else begin
      pre <= unit_tick ? '0 : pre + PW'(1);
      if (unit_tick) ticks <= round_start ? '0 : ticks + FW'(1);
    end
  end

  // a unit is at least 256 clocks, so two starts are never adjacent
  assert_start_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    round_start |=> !round_start);
endmodule

// File: rtl/tsq_engine.sv
module tsq_engine
  import tsq_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     round_start,
  input  logic [TSQ_NS-1:0]        en_mask,
  input  logic [1:0]               wr_ctl,
  input  logic [5:0]               vld_cfg,
  input  logic                     rd_sep,
  input  logic [4:0]               v_shift,
  input  logic [31:0]              poll_gap,
  input  logic [31:0]              tmo_lim,
  input  logic [31:0]              a_pnp,
  input  logic [31:0]              a_mux,
  input  logic [31:0]              a_en,
  input  logic [31:0]              a_vld,
  input  logic [31:0]              a_volt,
  input  logic [31:0]              d_mux,
  input  logic [31:0]              d_en,
  input  logic [TSQ_NS-1:0][31:0]  smux,
  output logic                     m_req,
  output logic                     m_we,
  output logic [31:0]              m_addr,
  output logic [31:0]              m_wdata,
  input  logic [31:0]              m_rdata,
  input  logic                     m_ack,
  output logic                     st_we,
  output logic [TSQ_SIW-1:0]       st_idx,
  output logic [11:0]              st_val,
  output logic                     tmo_err
);
  eng_state_t         st;
  logic [TSQ_SIW-1:0] cur;
  logic [31:0]        tmo_cnt;
  logic [31:0]        gap_cnt;
  logic [TSQ_SIW:0]   nxt;
  logic [TSQ_SIW:0]   first;
  logic               poll_hit;
  logic               tmo_over;

  assign nxt      = pick_next(en_mask, int'(cur) + 1);
  assign first    = pick_next(en_mask, 0);
  assign poll_hit = valid_seen(m_rdata, vld_cfg);
  assign tmo_over = (tmo_lim != '1) && (tmo_cnt >= tmo_lim);

  always_comb begin
    m_req   = 1'b0;
    m_we    = 1'b0;
    m_addr  = '0;
    m_wdata = '0;
    unique case (st)
      S_WR_PNP:  begin m_req = 1'b1; m_we = 1'b1; m_addr = a_pnp; m_wdata = smux[cur]; end
      S_WR_MUX:  begin m_req = 1'b1; m_we = 1'b1; m_addr = a_mux; m_wdata = d_mux; end
      S_WR_EN:   begin m_req = 1'b1; m_we = 1'b1; m_addr = a_en;  m_wdata = d_en; end
      S_RD_VLD:  begin m_req = 1'b1; m_addr = a_vld; end
      S_RD_VOLT: begin m_req = 1'b1; m_addr = a_volt; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cur     <= '0;
      tmo_cnt <= '0;
      gap_cnt <= '0;
      st_we   <= 1'b0;
      st_idx  <= '0;
      st_val  <= '0;
      tmo_err <= 1'b0;
    end else begin
      st_we   <= 1'b0;
      tmo_err <= 1'b0;
      unique case (st)
        S_IDLE:
          if (round_start && first[TSQ_SIW]) begin
            cur <= first[TSQ_SIW-1:0];
            st  <= entry_state(wr_ctl);
          end
        S_WR_PNP: if (m_ack) st <= wr_ctl[1] ? S_WR_MUX : S_WR_EN;
        S_WR_MUX: if (m_ack) st <= S_WR_EN;
        S_WR_EN:
          if (m_ack) begin
            tmo_cnt <= '0;
            st      <= S_RD_VLD;
          end
        S_RD_VLD: begin
          tmo_cnt <= tmo_cnt + 32'd1;
          if (m_ack) begin
            if (poll_hit) begin
              if (rd_sep) st <= S_RD_VOLT;
              else begin
                st_we  <= 1'b1;
                st_idx <= cur;
                st_val <= scale_sample(m_rdata, v_shift);
                if (nxt[TSQ_SIW]) begin cur <= nxt[TSQ_SIW-1:0]; st <= entry_state(wr_ctl); end
                else st <= S_IDLE;
              end
            end else if (tmo_over) begin
              tmo_err <= 1'b1;
              if (nxt[TSQ_SIW]) begin cur <= nxt[TSQ_SIW-1:0]; st <= entry_state(wr_ctl); end
              else st <= S_IDLE;
            end else begin
              gap_cnt <= '0;
              st      <= (poll_gap == '0) ? S_RD_VLD : S_GAP;
            end
          end
        end
        S_GAP: begin
          tmo_cnt <= tmo_cnt + 32'd1;
          gap_cnt <= gap_cnt + 32'd1;
          if (gap_cnt + 32'd1 >= poll_gap) st <= S_RD_VLD;
        end
        S_RD_VOLT:
          if (m_ack) begin
            st_we  <= 1'b1;
            st_idx <= cur;
            st_val <= scale_sample(m_rdata, v_shift);
            if (nxt[TSQ_SIW]) begin cur <= nxt[TSQ_SIW-1:0]; st <= entry_state(wr_ctl); end
            else st <= S_IDLE;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_we)));
  assert_store_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> en_mask[st_idx]);
  assert_tmo_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |-> (tmo_lim != '1));
  assert_err_no_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(tmo_err && st_we));
endmodule

// File: rtl/tsq_regs.sv
module tsq_regs
  import tsq_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic                     cfg_re,
  input  logic [TSQ_AW-1:0]        cfg_addr,
  input  logic [31:0]              cfg_wdata,
  output logic [31:0]              cfg_rdata,
  input  logic                     st_we,
  input  logic [TSQ_SIW-1:0]       st_idx,
  input  logic [11:0]              st_val,
  output logic [TSQ_NS-1:0]        en_mask,
  output logic [9:0]               unit_cnt,
  output logic [9:0]               ivl_cnt,
  output logic [1:0]               wr_ctl,
  output logic [5:0]               vld_cfg,
  output logic                     rd_sep,
  output logic [4:0]               v_shift,
  output logic [31:0]              poll_gap,
  output logic [31:0]              tmo_lim,
  output logic [31:0]              a_pnp,
  output logic [31:0]              a_mux,
  output logic [31:0]              a_en,
  output logic [31:0]              a_vld,
  output logic [31:0]              a_volt,
  output logic [31:0]              d_mux,
  output logic [31:0]              d_en,
  output logic [TSQ_NS-1:0][31:0]  smux
);
  logic [9:0]               filt_cnt;
  logic [TSQ_NS-1:0][11:0]  meas_val;
  logic [TSQ_NS-1:0]        meas_upd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_mask <= '0; unit_cnt <= '0; ivl_cnt <= '0; filt_cnt <= '0;
      wr_ctl <= '0; vld_cfg <= '0; rd_sep <= 1'b0; v_shift <= '0;
      poll_gap <= '0; tmo_lim <= '1;
      a_pnp <= '0; a_mux <= '0; a_en <= '0; a_vld <= '0; a_volt <= '0;
      d_mux <= '0; d_en <= '0;
    end else if (cfg_we) begin
      unique case (cfg_addr)
        RA_MASK:  en_mask  <= cfg_wdata[TSQ_NS-1:0];
        RA_UNIT:  unit_cnt <= cfg_wdata[9:0];
        RA_IVL:   begin ivl_cnt <= cfg_wdata[9:0]; filt_cnt <= cfg_wdata[25:16]; end
        RA_GAP:   poll_gap <= cfg_wdata;
        RA_TMO:   tmo_lim  <= cfg_wdata;
        RA_WRC:   wr_ctl   <= cfg_wdata[1:0];
        RA_VCFG:  vld_cfg  <= cfg_wdata[5:0];
        RA_RDC:   rd_sep   <= cfg_wdata[0];
        RA_SHIFT: v_shift  <= cfg_wdata[4:0];
        RA_APNP:  a_pnp    <= cfg_wdata;
        RA_AMUX:  a_mux    <= cfg_wdata;
        RA_AEN:   a_en     <= cfg_wdata;
        RA_AVLD:  a_vld    <= cfg_wdata;
        RA_AVOLT: a_volt   <= cfg_wdata;
        RA_DMUX:  d_mux    <= cfg_wdata;
        RA_DEN:   d_en     <= cfg_wdata;
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < TSQ_NS; i++) begin : g_sens
    always_ff @(posedge clk) begin
      if (!rst_n) smux[i] <= '0;
      else if (cfg_we && cfg_addr == RA_SMUX0 + TSQ_AW'(i)) smux[i] <= cfg_wdata;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        meas_val[i] <= '0;
        meas_upd[i] <= 1'b0;
      end else begin
        if (cfg_re && cfg_addr == RA_MEAS0 + TSQ_AW'(i)) meas_upd[i] <= 1'b0;
        if (st_we && st_idx == TSQ_SIW'(i)) begin
          meas_val[i] <= st_val;
          meas_upd[i] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr >= RA_MEAS0 && cfg_addr < RA_MEAS0 + TSQ_AW'(TSQ_NS)) begin
      cfg_rdata = {meas_upd[TSQ_SIW'(cfg_addr - RA_MEAS0)], 19'd0,
                   meas_val[TSQ_SIW'(cfg_addr - RA_MEAS0)]};
    end else if (cfg_addr >= RA_SMUX0 && cfg_addr < RA_SMUX0 + TSQ_AW'(TSQ_NS)) begin
      cfg_rdata = smux[TSQ_SIW'(cfg_addr - RA_SMUX0)];
    end else begin
      unique case (cfg_addr)
        RA_MASK:  cfg_rdata = 32'(en_mask);
        RA_UNIT:  cfg_rdata = 32'(unit_cnt);
        RA_IVL:   cfg_rdata = {6'd0, filt_cnt, 6'd0, ivl_cnt};
        RA_GAP:   cfg_rdata = poll_gap;
        RA_TMO:   cfg_rdata = tmo_lim;
        RA_WRC:   cfg_rdata = 32'(wr_ctl);
        RA_VCFG:  cfg_rdata = 32'(vld_cfg);
        RA_RDC:   cfg_rdata = 32'(rd_sep);
        RA_SHIFT: cfg_rdata = 32'(v_shift);
        RA_APNP:  cfg_rdata = a_pnp;
        RA_AMUX:  cfg_rdata = a_mux;
        RA_AEN:   cfg_rdata = a_en;
        RA_AVLD:  cfg_rdata = a_vld;
        RA_AVOLT: cfg_rdata = a_volt;
        RA_DMUX:  cfg_rdata = d_mux;
        RA_DEN:   cfg_rdata = d_en;
        default:  cfg_rdata = '0;
      endcase
    end
  end

  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |=> meas_upd[$past(st_idx)]);
  assert_value_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !st_we |=> $stable(meas_val));
endmodule

// File: rtl/tsq_top.sv
module tsq_top
  import tsq_pkg::*;
#(
  parameter int UNIT_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_re,
  input  logic [TSQ_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              m_req,
  output logic              m_we,
  output logic [31:0]       m_addr,
  output logic [31:0]       m_wdata,
  input  logic [31:0]       m_rdata,
  input  logic              m_ack,
  output logic              tmo_err
);
  logic [TSQ_NS-1:0]       en_mask;
  logic [9:0]              unit_cnt, ivl_cnt;
  logic [1:0]              wr_ctl;
  logic [5:0]              vld_cfg;
  logic                    rd_sep;
  logic [4:0]              v_shift;
  logic [31:0]             poll_gap, tmo_lim;
  logic [31:0]             a_pnp, a_mux, a_en, a_vld, a_volt, d_mux, d_en;
  logic [TSQ_NS-1:0][31:0] smux;
  logic                    round_start;
  logic                    st_we;
  logic [TSQ_SIW-1:0]      st_idx;
  logic [11:0]             st_val;

  tsq_regs u_regs (
    .clk, .rst_n, .cfg_we, .cfg_re, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .st_we, .st_idx, .st_val,
    .en_mask, .unit_cnt, .ivl_cnt, .wr_ctl, .vld_cfg, .rd_sep, .v_shift,
    .poll_gap, .tmo_lim, .a_pnp, .a_mux, .a_en, .a_vld, .a_volt,
    .d_mux, .d_en, .smux
  );

  tsq_pacer #(.UNIT_SHIFT(UNIT_SHIFT), .FW(10)) u_pacer (
    .clk, .rst_n, .unit_cnt, .ivl_cnt, .round_start
  );

  tsq_engine u_eng (
    .clk, .rst_n, .round_start, .en_mask, .wr_ctl, .vld_cfg, .rd_sep,
    .v_shift, .poll_gap, .tmo_lim, .a_pnp, .a_mux, .a_en, .a_vld,
    .a_volt, .d_mux, .d_en, .smux,
    .m_req, .m_we, .m_addr, .m_wdata, .m_rdata, .m_ack,
    .st_we, .st_idx, .st_val, .tmo_err
  );

  assert_idle_after_reset_R1: assert property (@(posedge clk)
    !rst_n |=> !m_req);
endmodule

// File: tb/tsq_top_test.sv
module tsq_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_re = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        m_req, m_we;
  logic [31:0] m_addr, m_wdata;
  logic [31:0] m_rdata = '0;
  logic        m_ack = 1'b0;
  logic        tmo_err;

  tsq_top uut (.*);

  always #5 clk = ~clk;

  localparam logic [31:0] A_PNP = 32'h1000_0604, A_MUX = 32'h2000_000C, A_EN = 32'h2000_0008;
  localparam logic [31:0] A_VLD = 32'h2000_0040, A_VOLT = 32'h2000_0044;
  localparam logic [31:0] D_MUX = 32'h0000_0800, D_EN = 32'h0000_0801;

  int checks = 0, fails = 0, cyc = 0, wr_cyc = 0, err_seen = 0;
  bit done = 0;
  logic [31:0] smux_v [4] = '{32'd0, 32'd1, 32'd2, 32'd16};
  logic [31:0] exp_q [$];   // expected writes: address, data pairs

  // behavioural ADC knobs
  int  k_pos = 12; bit k_pol = 1; int k_sh = 0; bit k_sep = 0;
  bit  k_stuck0 = 0; int left = 0; logic [31:0] last_pnp = 0;

  function automatic logic [11:0] val_of(input logic [31:0] p);
    return 12'h300 + 12'(p * 7);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(posedge clk); wr_cyc = cyc;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a; cfg_re = 1'b1; #1 d = cfg_rdata;
    @(posedge clk);
    @(negedge clk); cfg_re = 1'b0;
  endtask

  task automatic expect_round(input logic [3:0] mask, input logic [1:0] wc);
    for (int i = 0; i < 4; i++) if (mask[i]) begin
      if (wc[0]) begin exp_q.push_back(A_PNP); exp_q.push_back(smux_v[i]); end
      if (wc[1]) begin exp_q.push_back(A_MUX); exp_q.push_back(D_MUX); end
      exp_q.push_back(A_EN); exp_q.push_back(D_EN);
    end
  endtask

  // run one round: start pacer (unit 1, interval 2, filter 1), stop it after the round
  task automatic one_round(input int hold, input bit time_it);
    int d;
    wr(5'h02, 32'h0001_0002);
    while (!m_req) @(negedge clk);
    d = cyc - wr_cyc;
    if (time_it) check("R2 start delay in window", 32'(d >= 505 && d <= 520), 32'd1);
    repeat (hold) @(negedge clk);
    wr(5'h02, 32'h0001_0000);
    repeat (60) @(negedge clk);
  endtask

  initial forever begin @(posedge clk); cyc++; end

  // ADC slave model and scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (tmo_err) err_seen++;
    if (m_ack) m_ack = 1'b0;
    else if (m_req) begin
      m_ack = 1'b1;
      if (m_we) begin
        if (exp_q.size() < 2) begin
          checks++; fails++;
          $display("FAIL R3 unexpected write actual=%h/%h expected=none", m_addr, m_wdata);
        end else begin
          logic [31:0] ea, ed;
          ea = exp_q.pop_front(); ed = exp_q.pop_front();
          check("R3 write address", m_addr, ea);
          check("R3 write data", m_wdata, ed);
        end
        if (m_addr == A_PNP) last_pnp = m_wdata;
        if (m_addr == A_EN) left = 3;
      end else if (m_addr == A_VLD) begin
        bit rdy;
        rdy = !(k_stuck0 && last_pnp == 0) && left == 0;
        if (left > 0) left--;
        m_rdata = k_sep ? (32'hABC << k_sh) : (32'(val_of(last_pnp)) << k_sh);
        m_rdata[k_pos] = rdy ? k_pol : !k_pol;
      end else begin
        m_rdata = 32'(val_of(last_pnp)) << k_sh;
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd(5'h18 + 5'(i), d); check("R1 measurement zero after reset", d, 32'd0);
    end
    check("R1 no request after reset", 32'(m_req), 32'd0);

    wr(5'h01, 32'd1); wr(5'h03, 32'd2); wr(5'h04, 32'hFFFF_FFFF);
    wr(5'h09, A_PNP); wr(5'h0A, A_MUX); wr(5'h0B, A_EN); wr(5'h0C, A_VLD);
    wr(5'h0D, A_VOLT); wr(5'h0E, D_MUX); wr(5'h0F, D_EN);
    for (int i = 0; i < 4; i++) wr(5'h10 + 5'(i), smux_v[i]);

    // R10 filter field beside the sensor interval
    wr(5'h02, 32'h0155_0000); rd(5'h02, d);
    check("R10 filter interval readback", d, 32'h0155_0000);
    repeat (600) @(negedge clk);
    check("R2 no round with interval zero", 32'(m_req), 32'd0);

    // case A: all sensors, both extra writes, bit 12 active high, same word, no shift
    wr(5'h00, 32'hF); wr(5'h05, 32'd3); wr(5'h06, 32'h2C); wr(5'h07, 32'd0); wr(5'h08, 32'd0);
    k_pos = 12; k_pol = 1; k_sh = 0; k_sep = 0;
    expect_round(4'hF, 2'd3);
    one_round(250, 1);
    check("R3 all expected writes seen (A)", 32'(exp_q.size()), 32'd0);
    for (int i = 0; i < 4; i++) begin
      rd(5'h18 + 5'(i), d);
      check("R6 R7 stored value and flag (A)", d, {1'b1, 19'd0, val_of(smux_v[i])});
      rd(5'h18 + 5'(i), d);
      check("R7 flag cleared by read", d, {1'b0, 19'd0, val_of(smux_v[i])});
    end

    // case B: sensors 0 and 2, enable write only, bit 3 active low, separate read, shift 4
    wr(5'h00, 32'h5); wr(5'h05, 32'd0); wr(5'h06, 32'h03); wr(5'h07, 32'd1); wr(5'h08, 32'd4);
    k_pos = 3; k_pol = 0; k_sh = 4; k_sep = 1;
    expect_round(4'h5, 2'd0);
    one_round(250, 0);
    check("R3 only enable writes (B)", 32'(exp_q.size()), 32'd0);
    rd(5'h18, d); check("R4 R5 R6 separate read shifted (B s0)", d, {1'b1, 19'd0, val_of(32'd16)});
    rd(5'h1A, d); check("R4 R5 R6 separate read shifted (B s2)", d, {1'b1, 19'd0, val_of(32'd16)});
    rd(5'h19, d); check("R8 disabled sensor 1 untouched", d, {1'b0, 19'd0, val_of(32'd1)});
    rd(5'h1B, d); check("R8 disabled sensor 3 untouched", d, {1'b0, 19'd0, val_of(32'd16)});

    // case C: finite timeout on stuck sensor 0, sensor 1 still converts
    wr(5'h00, 32'h3); wr(5'h05, 32'd1); wr(5'h06, 32'h2C); wr(5'h07, 32'd0); wr(5'h08, 32'd0);
    wr(5'h04, 32'd40);
    k_pos = 12; k_pol = 1; k_sh = 0; k_sep = 0; k_stuck0 = 1; err_seen = 0;
    expect_round(4'h3, 2'd1);
    one_round(250, 0);
    check("R9 one timeout pulse", 32'(err_seen), 32'd1);
    rd(5'h18, d); check("R9 timed-out sensor not stored", d, {1'b0, 19'd0, val_of(32'd16)});
    rd(5'h19, d); check("R9 next sensor still converted", d, {1'b1, 19'd0, val_of(32'd1)});
    check("R3 all expected writes seen (C)", 32'(exp_q.size()), 32'd0);

    // case D: all-ones timeout keeps polling until the conversion finishes
    wr(5'h00, 32'h1); wr(5'h04, 32'hFFFF_FFFF); err_seen = 0;
    expect_round(4'h1, 2'd1);
    one_round(300, 0);
    check("R9 no timeout with all-ones limit", 32'(err_seen), 32'd0);
    rd(5'h18, d); check("R9 still waiting, nothing stored", d[31], 1'b0);
    k_stuck0 = 0;
    repeat (40) @(negedge clk);
    rd(5'h18, d); check("R9 stored once conversion completes", d, {1'b1, 19'd0, val_of(32'd0)});

    // unit zero blocks rounds even with a nonzero interval
    wr(5'h01, 32'd0); wr(5'h02, 32'd1);
    repeat (1000) @(negedge clk);
    check("R2 no round with unit zero", 32'(m_req), 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule